// File: doc/BRIEF.md
# Training-Sequence Consecutive-Match Tracker

This block sits behind the ordered-set decoder of a serial link receiver, one slot per lane. For every decoded ordered set it is told the set type, whether the link-number and lane-number fields both carried the PAD symbol, and the eight bits of symbol 5. From that stream it keeps three running counts per lane and drives three level flags that the link-training state machine reads.

The first flag, `qual_ok`, reports that eight back-to-back sets on the lane met the polling qualification rule. The second, `lpbk_req`, reports two back-to-back TS1 sets that ask for loopback. The third, `hrst_req`, reports two back-to-back TS1 sets that ask for a hot reset. A run breaks on any decoded set that does not match. Cycles with no decoded set leave the counts unchanged. A synchronous clear empties every lane at once. The training state machine uses the clear when it enters a new substate.

Top module: `ts_match_tracker`

## Requirements
- R1: After reset every bit of `qual_ok`, `lpbk_req` and `hrst_req` is 0.
- R2: A TS1 set (`os_kind` = 2'b01) with `os_pad` = 1 and symbol-5 bit 4 (compliance-receive) equal to 0 counts as qualifying.
- R3: A TS1 set with `os_pad` = 1 and symbol-5 bit 2 (loopback) equal to 1 counts as qualifying even when bit 4 is 1.
- R4: A TS2 set (`os_kind` = 2'b10) with `os_pad` = 1 counts as qualifying whatever symbol 5 holds.
- R5: On a lane, a decoded set that does not qualify resets the qualifying count to 0. Such a set is one with `os_pad` = 0, with `os_kind` 2'b00 or 2'b11, or a TS1 with bit 4 = 1 and bit 2 = 0.
- R6: `qual_ok` of a lane is 1 from the clock edge that takes the eighth consecutive qualifying set. It stays 1 while further qualifying sets arrive, because the count saturates and does not wrap.
- R7: `lpbk_req` of a lane is 1 after two consecutive decoded sets are TS1 with symbol-5 bit 2 set, whatever `os_pad` holds. Any other decoded set on the lane drops it to 0.
- R8: `hrst_req` of a lane is 1 after two consecutive decoded sets are TS1 with symbol-5 bit `HRST_BIT` set (default bit 0), whatever `os_pad` holds. Any other decoded set on the lane drops it to 0.
- R9: A cycle with `os_valid` low on a lane leaves all three counts and flags of that lane unchanged.
- R10: `clr` high at a clock edge returns every count and flag of every lane to 0, taking priority over a set decoded in the same cycle.
- R11: The lanes are independent. Sets on one lane never change the flags of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all lanes |
| os_valid | input | LANES | A decoded set is present on the lane this cycle |
| os_kind | input | 2*LANES | Set type per lane: 01 TS1, 10 TS2, 00/11 other |
| os_pad | input | LANES | Link and lane number fields were both PAD |
| os_sym5 | input | 8*LANES | Symbol 5 of the set, per lane |
| qual_ok | output | LANES | Eight consecutive qualifying sets seen |
| lpbk_req | output | LANES | Two consecutive loopback TS1 sets seen |
| hrst_req | output | LANES | Two consecutive hot-reset TS1 sets seen |

## Verification
Directed runs feed one lane three kinds of eight-set runs: TS1 with compliance-receive clear, TS1 with loopback set and compliance-receive set, and TS2 with arbitrary symbol 5. These runs separate the three ways a set can qualify. Further directed runs break a run with a compliance-only TS1, pad idle cycles into a run, and assert the clear together with a valid set. They show which events reset the count and which leave it alone. Loopback and hot-reset pairs are sent without PAD, to show that PAD does not gate those requests. A run is also placed on a neighbouring lane to show that lanes stay apart. A long random phase then mixes set types, PAD values, symbol-5 bits, idle cycles and clears on all lanes, against a per-lane count model kept in the bench.

// File: rtl/ts_track_pkg.sv
package ts_track_pkg;
    typedef enum logic [1:0] {
        OS_OTHER = 2'b00,
        OS_TS1   = 2'b01,
        OS_TS2   = 2'b10,
        OS_RSVD  = 2'b11
    } os_kind_e;

    localparam int SYM_W = 8;
endpackage

// File: rtl/ts_os_classify.sv
module ts_os_classify
    import ts_track_pkg::*;
#(
    parameter int CMP_BIT  = 4,
    parameter int LPBK_BIT = 2,
    parameter int HRST_BIT = 0
) (
    input  logic [1:0]       kind,
    input  logic             pad,
    input  logic [SYM_W-1:0] sym5,
    output logic             qual_hit,
    output logic             lpbk_hit,
    output logic             hrst_hit
);
    os_kind_e kind_e;
    logic     is_ts1;
    logic     is_ts2;

    always_comb begin
        kind_e   = os_kind_e'(kind);
        is_ts1   = (kind_e == OS_TS1);
        is_ts2   = (kind_e == OS_TS2);
        qual_hit = pad && (is_ts2 || (is_ts1 && (!sym5[CMP_BIT] || sym5[LPBK_BIT])));
        lpbk_hit = is_ts1 && sym5[LPBK_BIT];
        hrst_hit = is_ts1 && sym5[HRST_BIT];
    end
endmodule

// File: rtl/ts_run_counter.sv
module ts_run_counter #(
    parameter int TARGET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic valid,
    input  logic hit,
    output logic reached
);
    localparam int CW = $clog2(TARGET + 1);
    localparam logic [CW-1:0] TOP = CW'(TARGET);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (valid) begin
            if (!hit)
                st_d.cnt = '0;
            else if (st_q.cnt != TOP)
                st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.done = (st_d.cnt == TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign reached = st_q.done;

    // R5
    miss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !hit && !clr) |=> (st_q.cnt == '0 && !reached));

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !reached));

    // R6
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && hit && !clr && st_q.cnt != TOP) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R6
    saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && hit && !clr && reached) |=> reached);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clr) |=> ($stable(st_q.cnt) && $stable(reached)));
endmodule

// File: rtl/ts_match_tracker.sv
module ts_match_tracker
    import ts_track_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int QUAL_TARGET = 8,
    parameter int PAIR_TARGET = 2,
    parameter int CMP_BIT     = 4,
    parameter int LPBK_BIT    = 2,
    parameter int HRST_BIT    = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [LANES-1:0]       os_valid,
    input  logic [2*LANES-1:0]     os_kind,
    input  logic [LANES-1:0]       os_pad,
    input  logic [SYM_W*LANES-1:0] os_sym5,
    output logic [LANES-1:0]       qual_ok,
    output logic [LANES-1:0]       lpbk_req,
    output logic [LANES-1:0]       hrst_req
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic q_hit, l_hit, h_hit;
        logic [SYM_W-1:0] s5;

        assign s5 = os_sym5[g*SYM_W +: SYM_W];

        ts_os_classify #(
            .CMP_BIT (CMP_BIT),
            .LPBK_BIT(LPBK_BIT),
            .HRST_BIT(HRST_BIT)
        ) u_cls (
            .kind    (os_kind[2*g +: 2]),
            .pad     (os_pad[g]),
            .sym5    (s5),
            .qual_hit(q_hit),
            .lpbk_hit(l_hit),
            .hrst_hit(h_hit)
        );

        ts_run_counter #(.TARGET(QUAL_TARGET)) u_qual (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .valid(os_valid[g]), .hit(q_hit), .reached(qual_ok[g])
        );

        ts_run_counter #(.TARGET(PAIR_TARGET)) u_lpbk (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .valid(os_valid[g]), .hit(l_hit), .reached(lpbk_req[g])
        );

        ts_run_counter #(.TARGET(PAIR_TARGET)) u_hrst (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .valid(os_valid[g]), .hit(h_hit), .reached(hrst_req[g])
        );

        // R6
        qual_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qual_ok[g]) |-> $past(os_valid[g] && os_pad[g] && !clr));

        // R7
        lpbk_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lpbk_req[g]) |-> $past(os_valid[g] && os_kind[2*g +: 2] == 2'b01
                                         && s5[LPBK_BIT]));

        // R8
        hrst_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hrst_req[g]) |-> $past(os_valid[g] && os_kind[2*g +: 2] == 2'b01
                                         && s5[HRST_BIT]));
    end
endmodule

// File: tb/ts_match_tracker_tb.sv
module ts_match_tracker_tb;
    localparam int L = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr = 1'b0;
    logic [L-1:0]   os_valid = '0;
    logic [2*L-1:0] os_kind = '0;
    logic [L-1:0]   os_pad = '0;
    logic [8*L-1:0] os_sym5 = '0;
    logic [L-1:0]   qual_ok, lpbk_req, hrst_req;

    int checks = 0;
    int fails  = 0;
    int mq[L], ml[L], mh[L];

    always #4 clk = ~clk;

    ts_match_tracker #(.LANES(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .os_valid(os_valid), .os_kind(os_kind), .os_pad(os_pad), .os_sym5(os_sym5),
        .qual_ok(qual_ok), .lpbk_req(lpbk_req), .hrst_req(hrst_req)
    );

    function automatic bit f_qual(logic [1:0] k, logic p, logic [7:0] s);
        return p && (k == 2'b10 || (k == 2'b01 && (!s[4] || s[2])));
    endfunction
    function automatic bit f_lpbk(logic [1:0] k, logic [7:0] s);
        return k == 2'b01 && s[2];
    endfunction
    function automatic bit f_hrst(logic [1:0] k, logic [7:0] s);
        return k == 2'b01 && s[0];
    endfunction
    function automatic int f_next(int c, bit hit, int top);
        if (!hit) return 0;
        return (c < top) ? c + 1 : top;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic set_lane(int l, logic v, logic [1:0] k, logic p, logic [7:0] s);
        os_valid[l]      = v;
        os_kind[2*l +: 2] = k;
        os_pad[l]        = p;
        os_sym5[8*l +: 8] = s;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        #1;
        for (int l = 0; l < L; l++) begin
            if (clr) begin
                mq[l] = 0; ml[l] = 0; mh[l] = 0;
            end else if (os_valid[l]) begin
                mq[l] = f_next(mq[l], f_qual(os_kind[2*l +: 2], os_pad[l], os_sym5[8*l +: 8]), 8);
                ml[l] = f_next(ml[l], f_lpbk(os_kind[2*l +: 2], os_sym5[8*l +: 8]), 2);
                mh[l] = f_next(mh[l], f_hrst(os_kind[2*l +: 2], os_sym5[8*l +: 8]), 2);
            end
        end
        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            check(tag, qual_ok[l],  mq[l] == 8, $sformatf("qual_ok[%0d]", l));
            check(tag, lpbk_req[l], ml[l] == 2, $sformatf("lpbk_req[%0d]", l));
            check(tag, hrst_req[l], mh[l] == 2, $sformatf("hrst_req[%0d]", l));
        end
        os_valid = '0;
        clr = 1'b0;
    endtask

    task automatic send(int l, logic [1:0] k, logic p, logic [7:0] s, int n, string tag);
        for (int i = 0; i < n; i++) begin
            set_lane(l, 1'b1, k, p, s);
            tick(tag);
        end
    endtask

    task automatic do_clear(string tag);
        clr = 1'b1;
        tick(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int l = 0; l < L; l++) begin
            mq[l] = 0; ml[l] = 0; mh[l] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs low after reset
        for (int l = 0; l < L; l++) begin
            check("R1", qual_ok[l], 1'b0, "qual_ok reset");
            check("R1", lpbk_req[l], 1'b0, "lpbk_req reset");
            check("R1", hrst_req[l], 1'b0, "hrst_req reset");
        end
        rst_n = 1'b1;
        tick("R1");

        // R2: TS1 PAD, compliance-receive clear
        send(0, 2'b01, 1'b1, 8'h00, 7, "R2");
        check("R2", qual_ok[0], 1'b0, "qual_ok after 7");
        send(0, 2'b01, 1'b1, 8'h00, 1, "R2");
        check("R2", qual_ok[0], 1'b1, "qual_ok after 8");
        do_clear("R10");

        // R3: TS1 PAD, loopback set, compliance-receive set
        send(0, 2'b01, 1'b1, 8'h14, 8, "R3");
        check("R3", qual_ok[0], 1'b1, "qual_ok via loopback bit");
        do_clear("R10");

        // R4 and R6: TS2 PAD, symbol 5 arbitrary, then saturation
        send(0, 2'b10, 1'b1, 8'hFF, 8, "R4");
        check("R4", qual_ok[0], 1'b1, "qual_ok via TS2");
        send(0, 2'b10, 1'b1, 8'h5A, 12, "R6");
        check("R6", qual_ok[0], 1'b1, "qual_ok saturated");

        // R5: compliance-only TS1 breaks the run
        send(0, 2'b01, 1'b1, 8'h10, 1, "R5");
        check("R5", qual_ok[0], 1'b0, "qual_ok after bad TS1");
        send(0, 2'b10, 1'b1, 8'h00, 7, "R5");
        send(0, 2'b10, 1'b0, 8'h00, 1, "R5");
        send(0, 2'b10, 1'b1, 8'h00, 7, "R5");
        check("R5", qual_ok[0], 1'b0, "qual_ok after non-PAD break");
        send(0, 2'b00, 1'b1, 8'h00, 1, "R5");
        send(0, 2'b10, 1'b1, 8'h00, 7, "R5");
        check("R5", qual_ok[0], 1'b0, "qual_ok after other-type break");

        // R9: idle cycles do not break the run
        do_clear("R10");
        send(0, 2'b10, 1'b1, 8'h00, 4, "R9");
        repeat (5) tick("R9");
        send(0, 2'b10, 1'b1, 8'h00, 4, "R9");
        check("R9", qual_ok[0], 1'b1, "qual_ok across idle gap");

        // R10: clear wins over a valid set in the same cycle
        set_lane(0, 1'b1, 2'b10, 1'b1, 8'h00);
        clr = 1'b1;
        tick("R10");
        check("R10", qual_ok[0], 1'b0, "qual_ok after clear with valid");

        // R7: loopback pair without PAD, then broken by TS2
        send(0, 2'b01, 1'b0, 8'h04, 1, "R7");
        check("R7", lpbk_req[0], 1'b0, "lpbk_req after one");
        send(0, 2'b01, 1'b0, 8'h04, 1, "R7");
        check("R7", lpbk_req[0], 1'b1, "lpbk_req after two");
        send(0, 2'b10, 1'b1, 8'h04, 1, "R7");
        check("R7", lpbk_req[0], 1'b0, "lpbk_req after TS2");

        // R8: hot-reset pair without PAD, broken by TS1 without the bit
        send(0, 2'b01, 1'b0, 8'h01, 2, "R8");
        check("R8", hrst_req[0], 1'b1, "hrst_req after two");
        send(0, 2'b01, 1'b0, 8'h00, 1, "R8");
        check("R8", hrst_req[0], 1'b0, "hrst_req after plain TS1");

        // R11: run on lane 1 while lane 0 sees other sets
        do_clear("R10");
        for (int i = 0; i < 8; i++) begin
            set_lane(1, 1'b1, 2'b10, 1'b1, 8'h00);
            set_lane(0, 1'b1, 2'b00, 1'b1, 8'h00);
            tick("R11");
        end
        check("R11", qual_ok[1], 1'b1, "qual_ok lane1");
        check("R11", qual_ok[0], 1'b0, "qual_ok lane0");
        check("R11", qual_ok[2], 1'b0, "qual_ok lane2");

        // Random mix on all lanes: R6 R7 R8 R9 R10
        for (int c = 0; c < 4000; c++) begin
            for (int l = 0; l < L; l++) begin
                int r;
                logic [1:0] k;
                r = int'($urandom % 8);
                k = (r < 3) ? 2'b01 : (r < 6) ? 2'b10 : (r == 6) ? 2'b00 : 2'b11;
                set_lane(l, ($urandom % 4) != 0, k, ($urandom % 8) != 0, 8'($urandom));
            end
            clr = (($urandom % 64) == 0);
            tick("R6 R7 R8 random");
        end

        finish_run();
    end
endmodule